// File: doc/BRIEF.md
# Switch Matrix Row Latch

This block connects an 8 by 8 grid of active-high switches to a processor's synchronous register bus. Software picks which switch row it wants to see by writing a strobe byte to a 2 KB address window. It then reads the same window to get that row's eight switch levels. A single window serves both purposes: a write selects the row and a read returns its columns.

The strobe byte is bits 15..8 of the written word. A set bit at position 8+k asks for row k. When several bits are set, the highest-numbered one wins. When none are set, the row selected before is kept. The low byte of the written word belongs to other logic, and this block ignores it. The raw switch levels come from mechanical contacts with no clock relationship to the bus. They pass through a two-flop synchronizer before the column selection.

The bus is a 17-bit address space divided into 2 KB windows. The row window sits at base 0x14000, so it is hit when address bits 16..11 equal 6'b101000. A read is answered one cycle later through a registered data word and a valid strobe.

Top module: `swrow_port`

## Requirements
- R1: While reset is held, and after its release, the latched row is 0, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: A write inside the window whose bits 15..8 hold only bit 8+k selects row k (k = 0..7) from the next clock edge. Bits 7..0 of the written word have no effect on the row.
- R3: A write inside the window with several of bits 15..8 set selects the row given by the highest set bit. For example, bit 15 set always selects row 7.
- R4: A write inside the window with bits 15..8 all zero leaves the latched row unchanged.
- R5: A write whose address bits 16..11 differ from 6'b101000 leaves the latched row unchanged.
- R6: A read inside the window gives `bus_rvalid` = 1 in the next cycle. `bus_rdata[7:0]` carries the synchronized switch levels of the latched row, with bit c taken from `sw_in[row*8+c]`. `bus_rdata[15:8]` is 0.
- R7: A read outside the window gives `bus_rvalid` = 0 and `bus_rdata` = 0 in the next cycle. Whenever `bus_rvalid` is 0, `bus_rdata` is 0.
- R8: Switch levels pass through two flops. A change applied in a cycle is not returned to reads issued in that cycle or the next one. It is returned to a read issued in the cycle after those two.
- R9: A cycle that both writes and reads inside the window returns the columns of the row that was latched before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 17 | Byte address of the access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wdata | input | 16 | Write data; bits 15..8 are the row strobe |
| sw_in | input | 64 | Raw switch levels, row r column c at bit r*8+c |
| bus_rdata | output | 16 | Read data, registered, zero when not valid |
| bus_rvalid | output | 1 | Read answer valid, one cycle after an in-window read |

## Verification
Every one of the 255 non-zero strobe bytes is written, and the row read back is compared with the highest-set-bit rule. This separates a correct priority encoder from one that favours the lowest bit or only handles one-hot values. Each row has a distinct column byte, so a wrong row index shows up as a wrong data value. A zero strobe byte, and addresses just outside the window, are written to show the latch holds. Reads issued back to back right after a switch change pin the synchronizer at exactly two stages. A combined write and read shows the read uses the row from before the write.

// File: rtl/swrow_pkg.sv
package swrow_pkg;
  localparam int unsigned ADDR_W_DEF   = 17;
  localparam int unsigned DATA_W_DEF   = 16;
  localparam int unsigned WIN_LOG2_DEF = 11;
  localparam int unsigned ROWS_DEF     = 8;
  localparam int unsigned COLS_DEF     = 8;
  localparam logic [ADDR_W_DEF-1:0] WIN_BASE_DEF = 17'h14000;
endpackage

// File: rtl/swrow_decode.sv
module swrow_decode #(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned WIN_LOG2 = 11,
  parameter logic [ADDR_W-1:0] BASE = 17'h14000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] TAG = BASE[ADDR_W-1:WIN_LOG2];

  // Only the bits above the window size take part in the compare.
  always_comb begin
    hit = (addr[ADDR_W-1:WIN_LOG2] == TAG);
  end
endmodule

// File: rtl/swrow_sync.sv
module swrow_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = d;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/swrow_select.sv
module swrow_select #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [ROWS-1:0]  strobe,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q, row_d;
  logic [ROW_W-1:0] pick;
  logic             any;

  // Ascending scan: a later (higher) set bit overwrites an earlier one.
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = 0; i < int'(ROWS); i++) begin
      if (strobe[i]) begin
        pick = ROW_W'(i);
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    row_d = row_q;
    if (load_en && any) begin
      row_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else begin
      row_q <= row_d;
    end
  end

  assign row = row_q;
endmodule

// File: rtl/swrow_port.sv
module swrow_port
  import swrow_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned WIN_LOG2 = WIN_LOG2_DEF,
  parameter int unsigned ROWS     = ROWS_DEF,
  parameter int unsigned COLS     = COLS_DEF,
  parameter logic [ADDR_W-1:0] WIN_BASE = WIN_BASE_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [ROWS*COLS-1:0] sw_in,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid
);
  localparam int unsigned ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned STROBE_LSB = DATA_W - ROWS;
  localparam int unsigned PAD_W      = DATA_W - COLS;

  // Reset: asserted at once, released after two clock edges.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic win_hit;
  swrow_decode #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .BASE(WIN_BASE)
  ) u_decode (
    .addr(bus_addr),
    .hit (win_hit)
  );

  logic [ROW_W-1:0] row_q;
  logic             row_load;
  always_comb begin
    row_load = bus_wr && win_hit;
  end

  swrow_select #(.ROWS(ROWS), .ROW_W(ROW_W)) u_select (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .load_en(row_load),
    .strobe (bus_wdata[STROBE_LSB +: ROWS]),
    .row    (row_q)
  );

  logic [ROWS*COLS-1:0] sw_sync;
  swrow_sync #(.WIDTH(ROWS*COLS)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .d    (sw_in),
    .q    (sw_sync)
  );

  logic [COLS-1:0] row_cols [ROWS];
  for (genvar r = 0; r < int'(ROWS); r++) begin : g_row
    assign row_cols[r] = sw_sync[r*COLS +: COLS];
  end

  logic [COLS-1:0] col_sel;
  always_comb begin
    col_sel = row_cols[row_q];
  end

  logic              rd_en;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rd_en    = bus_rd && win_hit;
    rvalid_d = rd_en;
    rdata_d  = '0;
    if (rd_en) begin
      rdata_d = {{PAD_W{1'b0}}, col_sel};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/swrow_port_chk.sv
module swrow_port_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ROW_W  = 3
) (
  input logic              clk,
  input logic              rst_sync_q,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              win_hit,
  input logic [ROW_W-1:0]  row_q,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid
);
  // R1 / R7: data is zero whenever no answer is valid
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !bus_rvalid |-> bus_rdata == '0);

  // R6: an in-window read is answered in the next cycle with a zero upper byte
  a_r6_answer: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_rd && win_hit) |=> (bus_rvalid && bus_rdata[DATA_W-1:DATA_W/2] == '0));

  // R7: an out-of-window read gives no answer
  a_r7_no_answer: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_rd && !win_hit) |=> !bus_rvalid);

  // R2: lone lowest strobe bit picks row 0
  a_r2_row0: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_wr && win_hit && bus_wdata[DATA_W-1:DATA_W/2] == 8'h01) |=> row_q == '0);

  // R3: top strobe bit dominates
  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_wr && win_hit && bus_wdata[DATA_W-1]) |=> row_q == '1);

  // R4: empty strobe byte keeps the row
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_wr && win_hit && bus_wdata[DATA_W-1:DATA_W/2] == '0) |=> $stable(row_q));

  // R5: writes elsewhere keep the row
  a_r5_outside: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_wr && !win_hit) |=> $stable(row_q));
endmodule

bind swrow_port swrow_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W)
) u_chk (
  .clk       (clk),
  .rst_sync_q(rst_sync_q),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .win_hit   (win_hit),
  .row_q     (row_q),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid)
);

// File: tb/swrow_port_tb.sv
module swrow_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] WIN = 17'h14000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [63:0] sw_in = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int errors = 0;
  logic [7:0] seed = 8'h00;

  swrow_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .sw_in(sw_in),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(int r, logic [7:0] s);
    return 8'(((r + 1) * 29) ^ (r << 5)) ^ s;
  endfunction

  function automatic int top_bit(logic [7:0] b);
    int t = -1;
    for (int i = 0; i < 8; i++) if (b[i]) t = i;
    return t;
  endfunction

  task automatic load_pattern(logic [7:0] s);
    for (int r = 0; r < 8; r++) sw_in[r*8 +: 8] = pat(r, s);
  endtask

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [16:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [16:0] a, output logic v, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rvalid; d = bus_rdata;
  endtask

  task automatic expect_row(string req, int r);
    logic v; logic [15:0] d;
    bus_read(WIN, v, d);
    check(req, {v, d}, {1'b1, 8'h00, pat(r, seed)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic v; logic [15:0] d;
    load_pattern(seed);
    repeat (3) @(negedge clk);
    check("R1 in reset", {bus_rvalid, bus_rdata}, 17'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 after release", {bus_rvalid, bus_rdata}, 17'h0);
    expect_row("R1 row 0 after reset", 0);

    // R2: each lone strobe bit, low byte noise ignored
    for (int k = 0; k < 8; k++) begin
      bus_write(WIN + 17'(k * 2), {8'(1 << k), 8'(8'hA5 + k)});
      expect_row("R2 one-hot strobe", k);
    end

    // R3: every non-zero strobe byte, highest bit wins
    for (int b = 1; b < 256; b++) begin
      bus_write(WIN + 17'h7FE, {8'(b), 8'hFF});
      expect_row("R3 priority", top_bit(8'(b)));
    end

    // R4: empty strobe keeps the row
    bus_write(WIN, 16'h0800);
    bus_write(WIN, 16'h00FF);
    expect_row("R4 hold on empty strobe", 3);

    // R5: writes just outside the window
    bus_write(WIN - 17'h1, 16'h8000);
    expect_row("R5 below window", 3);
    bus_write(WIN + 17'h800, 16'h0100);
    expect_row("R5 above window", 3);
    bus_write(17'h04000, 16'h4000);
    expect_row("R5 far address", 3);

    // R7: read outside window
    bus_read(WIN + 17'h800, v, d);
    check("R7 read outside", {v, d}, 17'h0);
    bus_read(WIN - 17'h2, v, d);
    check("R7 read below", {v, d}, 17'h0);

    // R6: several switch patterns on every row
    for (int s = 0; s < 4; s++) begin
      seed = 8'(s * 8'h55 + 8'h0F);
      load_pattern(seed);
      repeat (3) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        bus_write(WIN, {8'(1 << k), 8'h00});
        expect_row("R6 columns of row", k);
      end
    end

    // R8: two-stage synchronizer latency, row 7 selected
    @(negedge clk);
    seed = 8'hC3;
    load_pattern(seed);
    bus_addr = WIN; bus_rd = 1'b1;
    @(negedge clk);
    check("R8 read same cycle", {bus_rvalid, bus_rdata},
          {1'b1, 8'h00, pat(7, 8'(3 * 8'h55 + 8'h0F))});
    @(negedge clk);
    check("R8 read next cycle", {bus_rvalid, bus_rdata},
          {1'b1, 8'h00, pat(7, 8'(3 * 8'h55 + 8'h0F))});
    @(negedge clk);
    check("R8 read third cycle", {bus_rvalid, bus_rdata}, {1'b1, 8'h00, pat(7, seed)});
    bus_rd = 1'b0;

    // R9: combined write and read returns the old row
    @(negedge clk);
    bus_addr = WIN; bus_wdata = 16'h0400; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9 old row on combined access", {bus_rvalid, bus_rdata}, {1'b1, 8'h00, pat(7, seed)});
    expect_row("R9 new row afterwards", 2);

    @(negedge clk);
    check("R7 idle after reads", {bus_rvalid, bus_rdata}, 17'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule